// File: doc/BRIEF.md
# Unaligned Word Load/Store Byte-Lane Merger

This block is the lane-steering helper that sits beside a 32-bit little-endian load/store unit and completes the four partial-word instructions that move the left or right part of an unaligned word. The pipeline has already read the naturally aligned memory word, the one at the effective address with its two low bits cleared. It hands the block that word together with the instruction kind, the effective address, the destination index, the current destination register value and the store source value.

For the two load kinds, the block returns the merged register value and a register write strobe. For the two store kinds, it returns the merged word to write back to the aligned address and a byte-enable. The byte-enable marks exactly the lanes whose bytes come from the register.

The block looks at the low address bits, which give the byte offset k, and picks one of four shift and mask patterns from the kind and k. It registers the result for exactly one cycle. Address translation and bus timing are handled outside the block.

Top module: `unaligned_merge`

## Requirements
- R1: One cycle after a request, `addr_o` holds the request address with its two low bits cleared. The offset k used for merging is `addr_i[1:0]`.
- R2: Kind code 2'b00 (load-left) gives `(reg & (0x00FFFFFF >> 8k)) | (mem << (24 - 8k))`. Any shift of 32 or more bits yields zero.
- R3: Kind code 2'b01 (load-right) gives `(reg & (0xFFFFFF00 << (24 - 8k))) | (mem >> 8k)`.
- R4: Kind code 2'b10 (store-left) gives `(reg >> (24 - 8k)) | (mem & (0xFFFFFF00 << 8k))`.
- R5: Kind code 2'b11 (store-right) gives `(reg << 8k) | (mem & (0x00FFFFFF >> (24 - 8k)))`.
- R6: `be_o` bit i stands for byte lane i, which is data bits 8i+7..8i. For store-left, lanes 0..k are set. For store-right, lanes k..3 are set. For both load kinds, `be_o` is zero.
- R7: `reg_we_o` is 1 after a load whose `dst_i` is nonzero. It is 0 after a load to index 0, even though the merged data is still produced. It is 0 after any store.
- R8: `vld_o` is 1 exactly in the cycle after a cycle with `req_i` high. In a cycle with no request, `vld_o` and `reg_we_o` fall to 0, while `data_o`, `be_o` and `addr_o` keep their last values.
- R9: A synchronous reset (`rst_i` high at a clock edge) clears `vld_o`, `data_o`, `be_o`, `addr_o` and `reg_we_o` to zero.
- R10: At the edge offsets the following hold. Load-left at k=3 and load-right at k=0 return the whole memory word. Store-right at k=0 writes the whole register. Store-left at k=0 changes only lane 0, and that lane takes the register's top byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, one operation per cycle |
| op_i | input | 2 | Kind: 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| addr_i | input | ADDR_W | Effective byte address |
| dst_i | input | REG_IDX_W | Destination register index for loads |
| reg_i | input | 8*LANES | Current destination value (loads) or source value (stores) |
| mem_i | input | 8*LANES | Aligned memory word |
| vld_o | output | 1 | Result valid |
| data_o | output | 8*LANES | Merged register value or merged store word |
| be_o | output | LANES | Store byte-enable, one bit per lane |
| addr_o | output | ADDR_W | Aligned word address |
| reg_we_o | output | 1 | Register write strobe for loads |

## Verification
The bench builds the block with its default parameters: LANES=4, ADDR_W=32 and REG_IDX_W=5. With four lanes, the two-bit offset covers every shift pattern of all four kinds, including both edge offsets, where a mask or shift reaches 32 bits and must give zero. A five-bit index makes index 0 reachable, so the suppressed register write can be tested. Two distinct register/memory byte patterns run through the merge, so a byte taken from the wrong lane or the wrong source shows up as a wrong value.

// File: rtl/uam_pkg.sv
package uam_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_LOAD_L  = 2'b00,
        OP_LOAD_R  = 2'b01,
        OP_STORE_L = 2'b10,
        OP_STORE_R = 2'b11
    } uam_op_e;

    function automatic logic is_store(input uam_op_e op);
        return (op == OP_STORE_L) || (op == OP_STORE_R);
    endfunction

endpackage

// File: rtl/uam_lane_map.sv
// Per-lane routing: which source (register or memory) feeds this lane,
// and which lane of that source it is taken from.
module uam_lane_map
    import uam_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LANE  = 0,
    localparam int OFF_W = $clog2(LANES)
) (
    input  uam_op_e          op_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             use_reg_o,
    output logic [OFF_W-1:0] idx_o
);
    localparam int TOP = LANES - 1;

    int k_v;
    int src_v;

    always_comb begin
        k_v       = int'(off_i);
        src_v     = LANE;
        use_reg_o = 1'b0;
        unique case (op_i)
            OP_LOAD_L: begin
                if (LANE >= TOP - k_v) begin
                    use_reg_o = 1'b0;
                    src_v     = LANE + k_v - TOP;
                end else begin
                    use_reg_o = 1'b1;
                end
            end
            OP_LOAD_R: begin
                if (LANE <= TOP - k_v) begin
                    use_reg_o = 1'b0;
                    src_v     = LANE + k_v;
                end else begin
                    use_reg_o = 1'b1;
                end
            end
            OP_STORE_L: begin
                if (LANE <= k_v) begin
                    use_reg_o = 1'b1;
                    src_v     = LANE + TOP - k_v;
                end
            end
            OP_STORE_R: begin
                if (LANE >= k_v) begin
                    use_reg_o = 1'b1;
                    src_v     = LANE - k_v;
                end
            end
            default: use_reg_o = 1'b0;
        endcase
        idx_o = src_v[OFF_W-1:0];
    end

endmodule

// File: rtl/uam_merge_core.sv
// Combinational byte-lane merge built from one lane map per lane.
module uam_merge_core
    import uam_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * BYTE_W
) (
    input  uam_op_e          op_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    reg_i,
    input  logic [DW-1:0]    mem_i,
    output logic [DW-1:0]    data_o,
    output logic [LANES-1:0] be_o
);
    localparam int SH = $clog2(BYTE_W);

    logic store_w;
    assign store_w = is_store(op_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic             use_reg;
        logic [OFF_W-1:0] idx;
        logic [OFF_W+SH-1:0] base;

        uam_lane_map #(
            .LANES (LANES),
            .LANE  (g)
        ) u_map (
            .op_i      (op_i),
            .off_i     (off_i),
            .use_reg_o (use_reg),
            .idx_o     (idx)
        );

        assign base = {idx, {SH{1'b0}}};
        assign data_o[g*BYTE_W +: BYTE_W] = use_reg ? reg_i[base +: BYTE_W]
                                                    : mem_i[base +: BYTE_W];
        assign be_o[g] = use_reg & store_w;
    end

    // Lane-count checks on the enables produced by the lane maps (R6)
    always_comb begin
        if (op_i == OP_STORE_L) begin
            p_swl_lane_count_r6: assert ($countones(be_o) == int'(off_i) + 1)
                else $error("store-left enable count wrong");
        end else if (op_i == OP_STORE_R) begin
            p_swr_lane_count_r6: assert ($countones(be_o) == LANES - int'(off_i))
                else $error("store-right enable count wrong");
        end else begin
            p_load_no_enable_r6: assert (be_o == '0)
                else $error("load produced byte enables");
        end
    end

endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
    import uam_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ADDR_W    = 32,
    parameter int REG_IDX_W = 5,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * BYTE_W
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 req_i,
    input  logic [1:0]           op_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [REG_IDX_W-1:0] dst_i,
    input  logic [DW-1:0]        reg_i,
    input  logic [DW-1:0]        mem_i,
    output logic                 vld_o,
    output logic [DW-1:0]        data_o,
    output logic [LANES-1:0]     be_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 reg_we_o
);
    typedef struct packed {
        logic              vld;
        logic [DW-1:0]     data;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic              reg_we;
    } state_t;

    state_t st_d, st_q;

    uam_op_e          op_w;
    logic [DW-1:0]    mrg_data_w;
    logic [LANES-1:0] mrg_be_w;

    assign op_w = uam_op_e'(op_i);

    uam_merge_core #(
        .LANES (LANES)
    ) u_core (
        .op_i   (op_w),
        .off_i  (addr_i[OFF_W-1:0]),
        .reg_i  (reg_i),
        .mem_i  (mem_i),
        .data_o (mrg_data_w),
        .be_o   (mrg_be_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = req_i;
        st_d.reg_we = 1'b0;
        if (req_i) begin
            st_d.data   = mrg_data_w;
            st_d.be     = mrg_be_w;
            st_d.addr   = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st_d.reg_we = !is_store(op_w) && (dst_i != '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o    = st_q.vld;
    assign data_o   = st_q.data;
    assign be_o     = st_q.be;
    assign addr_o   = st_q.addr;
    assign reg_we_o = st_q.reg_we;

    p_vld_follows_req_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> vld_o)
        else $error("valid missing after request");

    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> (!vld_o && !reg_we_o && $stable(data_o) && $stable(be_o)))
        else $error("outputs moved without request");

    p_zero_dst_no_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && dst_i == '0) |=> !reg_we_o)
        else $error("write strobe for index zero");

    p_store_no_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && is_store(op_w)) |=> !reg_we_o)
        else $error("write strobe after store");

    p_addr_aligned_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> (addr_o[OFF_W-1:0] == '0))
        else $error("unaligned output address");

    p_swr_full_word_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && op_w == OP_STORE_R && addr_i[OFF_W-1:0] == '0) |=> (be_o == '1 && data_o == $past(reg_i)))
        else $error("store-right at offset zero not whole word");

    p_reset_clears_r9: assert property (@(posedge clk_i)
        rst_i |=> (!vld_o && !reg_we_o && be_o == '0 && data_o == '0))
        else $error("reset did not clear outputs");

endmodule

// File: tb/unaligned_merge_tb_top.sv
module unaligned_merge_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [1:0]  op;
    logic [31:0] addr;
    logic [4:0]  dst;
    logic [31:0] rv;
    logic [31:0] mv;
    logic        vld;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] aout;
    logic        we;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    unaligned_merge dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .req_i    (req),
        .op_i     (op),
        .addr_i   (addr),
        .dst_i    (dst),
        .reg_i    (rv),
        .mem_i    (mv),
        .vld_o    (vld),
        .data_o   (data),
        .be_o     (be),
        .addr_o   (aout),
        .reg_we_o (we)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [4:0]  dst;
        logic [31:0] rv;
        logic [31:0] mv;
        logic [31:0] exp;
        logic [3:0]  be;
        logic        we;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{2'b00, 32'h0000_2000, 5'd7, 32'hAABBCCDD, 32'h11223344, 32'h44BBCCDD, 4'h0, 1'b1},
        '{2'b00, 32'h0000_2001, 5'd7, 32'hAABBCCDD, 32'h11223344, 32'h3344CCDD, 4'h0, 1'b1},
        '{2'b00, 32'h0000_2002, 5'd7, 32'hAABBCCDD, 32'h11223344, 32'h223344DD, 4'h0, 1'b1},
        '{2'b00, 32'h0000_2003, 5'd7, 32'hAABBCCDD, 32'h11223344, 32'h11223344, 4'h0, 1'b1},
        '{2'b01, 32'h0000_3004, 5'd9, 32'hAABBCCDD, 32'h11223344, 32'h11223344, 4'h0, 1'b1},
        '{2'b01, 32'h0000_3005, 5'd9, 32'hAABBCCDD, 32'h11223344, 32'hAA112233, 4'h0, 1'b1},
        '{2'b01, 32'h0000_3006, 5'd9, 32'hAABBCCDD, 32'h11223344, 32'hAABB1122, 4'h0, 1'b1},
        '{2'b01, 32'h0000_3007, 5'd9, 32'hAABBCCDD, 32'h11223344, 32'hAABBCC11, 4'h0, 1'b1},
        '{2'b10, 32'h0000_4008, 5'd3, 32'hAABBCCDD, 32'h11223344, 32'h112233AA, 4'h1, 1'b0},
        '{2'b10, 32'h0000_4009, 5'd3, 32'hAABBCCDD, 32'h11223344, 32'h1122AABB, 4'h3, 1'b0},
        '{2'b10, 32'h0000_400A, 5'd3, 32'hAABBCCDD, 32'h11223344, 32'h11AABBCC, 4'h7, 1'b0},
        '{2'b10, 32'h0000_400B, 5'd3, 32'hAABBCCDD, 32'h11223344, 32'hAABBCCDD, 4'hF, 1'b0},
        '{2'b11, 32'h0000_500C, 5'd0, 32'hAABBCCDD, 32'h11223344, 32'hAABBCCDD, 4'hF, 1'b0},
        '{2'b11, 32'h0000_500D, 5'd0, 32'hAABBCCDD, 32'h11223344, 32'hBBCCDD44, 4'hE, 1'b0},
        '{2'b11, 32'h0000_500E, 5'd0, 32'hAABBCCDD, 32'h11223344, 32'hCCDD3344, 4'hC, 1'b0},
        '{2'b11, 32'h0000_500F, 5'd0, 32'hAABBCCDD, 32'h11223344, 32'hDD223344, 4'h8, 1'b0},
        '{2'b00, 32'hFFFF_FFF1, 5'd31, 32'h01020304, 32'hF0E0D0C0, 32'hD0C00304, 4'h0, 1'b1},
        '{2'b01, 32'h8000_0012, 5'd1,  32'h01020304, 32'hF0E0D0C0, 32'h0102F0E0, 4'h0, 1'b1},
        '{2'b10, 32'h1234_5676, 5'd1,  32'h01020304, 32'hF0E0D0C0, 32'hF0010203, 4'h7, 1'b0},
        '{2'b11, 32'h0000_0021, 5'd1,  32'h01020304, 32'hF0E0D0C0, 32'h020304C0, 4'hE, 1'b0}
    };

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request cycle; returns at the negedge after the capturing edge.
    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [4:0] d,
                         input logic [31:0] r, input logic [31:0] m);
        @(negedge clk);
        req = 1'b1; op = o; addr = a; dst = d; rv = r; mv = m;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = 1'b0; op = 2'b00; addr = '0; dst = '0; rv = '0; mv = '0;
        repeat (3) @(negedge clk);
        // r9_ reset state
        chk("R9 vld", {31'b0, vld}, 32'h0);
        chk("R9 data", data, 32'h0);
        chk("R9 be", {28'b0, be}, 32'h0);
        chk("R9 addr", aout, 32'h0);
        chk("R9 we", {31'b0, we}, 32'h0);
        rst = 1'b0;

        // Table walk: R1..R8 under two byte patterns
        for (int i = 0; i < NV; i++) begin
            issue(VT[i].op, VT[i].addr, VT[i].dst, VT[i].rv, VT[i].mv);
            chk({op_tag(VT[i].op), " data"}, data, VT[i].exp);
            chk("R6 be", {28'b0, be}, {28'b0, VT[i].be});
            chk("R7 we", {31'b0, we}, {31'b0, VT[i].we});
            chk("R8 vld", {31'b0, vld}, 32'h1);
            chk("R1 addr", aout, VT[i].addr & ~32'h3);
        end

        // R7: load to index zero still merges but does not write
        issue(2'b00, 32'h0000_6001, 5'd0, 32'hAABBCCDD, 32'h11223344);
        chk("R7 zero-dst we", {31'b0, we}, 32'h0);
        chk("R7 zero-dst data", data, 32'h3344CCDD);
        chk("R7 zero-dst vld", {31'b0, vld}, 32'h1);

        // R8: idle cycles keep data/be/addr, drop valid and write strobe
        issue(2'b10, 32'h0000_7002, 5'd4, 32'hAABBCCDD, 32'h11223344);
        repeat (3) @(negedge clk);
        chk("R8 idle vld", {31'b0, vld}, 32'h0);
        chk("R8 idle data", data, 32'h11AABBCC);
        chk("R8 idle be", {28'b0, be}, 32'h7);
        chk("R8 idle addr", aout, 32'h0000_7000);
        issue(2'b01, 32'h0000_7101, 5'd4, 32'hAABBCCDD, 32'h11223344);
        @(negedge clk);
        chk("R8 idle we", {31'b0, we}, 32'h0);

        // R8: back-to-back requests, each result in the following cycle
        @(negedge clk);
        req = 1'b1; op = 2'b11; addr = 32'h0000_8003; dst = 5'd2; rv = 32'h01020304; mv = 32'hF0E0D0C0;
        @(negedge clk);
        chk("R8 b2b first", data, 32'h04E0D0C0);
        chk("R5 b2b be", {28'b0, be}, 32'h8);
        op = 2'b00; addr = 32'h0000_8102;
        @(negedge clk);
        req = 1'b0;
        chk("R8 b2b second", data, 32'hE0D0C004);
        chk("R8 b2b vld", {31'b0, vld}, 32'h1);
        chk("R7 b2b we", {31'b0, we}, 32'h1);

        // R10: edge offsets with a fresh pattern
        issue(2'b00, 32'h0000_9003, 5'd5, 32'h5A5A5A5A, 32'hDEADBEEF);
        chk("R10 load-left k3 whole mem", data, 32'hDEADBEEF);
        issue(2'b01, 32'h0000_9000, 5'd5, 32'h5A5A5A5A, 32'hDEADBEEF);
        chk("R10 load-right k0 whole mem", data, 32'hDEADBEEF);
        issue(2'b11, 32'h0000_9000, 5'd5, 32'h5A5A5A5A, 32'hDEADBEEF);
        chk("R10 store-right k0 whole reg", data, 32'h5A5A5A5A);
        chk("R10 store-right k0 be", {28'b0, be}, 32'hF);
        issue(2'b10, 32'h0000_9000, 5'd5, 32'h7711AA5A, 32'hDEADBEEF);
        chk("R10 store-left k0 lane0", data, 32'hDEADBE77);
        chk("R10 store-left k0 be", {28'b0, be}, 32'h1);

        // R9: reset while a result is held
        issue(2'b00, 32'h0000_A001, 5'd6, 32'hAABBCCDD, 32'h11223344);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid vld", {31'b0, vld}, 32'h0);
        chk("R9 mid data", data, 32'h0);
        chk("R9 mid addr", aout, 32'h0);
        chk("R9 mid we", {31'b0, we}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule